// File: doc/BRIEF.md
# Bus master acquisition event monitor

This block watches one composite bus agent on a shared parallel bus and counts one selected event. The agent is made up of several internal requesters. Their request lines are merged into a single agent request, and each requester also has a grant line of its own. A small configuration write chooses what the counter measures. It can count how many new transactions the agent won as master, or how many clocks the agent spent waiting for the bus, or how many clocks the agent spent owning it. A fourth code stops counting.

Software reads the grant count and the waiting clocks in two separate runs. Dividing one by the other gives the average acquisition latency; the block does not do that division. The counter is free-running inside a run. It saturates at its maximum value and then raises a sticky overflow flag. Writing the selection clears both the counter and the flag in the same cycle. Events are counted again from the next clock.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal, sampled or updated on each rising clock edge.

Top module: `bmon_top`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` is 0 and the selection is the off code (3), so no event is counted until a selection is written.
- R2: On a clock with `cfg_we_i` high, the selection takes the value of `cfg_sel_i` and, after that edge, `count_o` is 0 and `ovf_o` is 0. No event present in that write cycle is counted.
- R3: When an increment would take the counter past 2^CNT_W-1, the counter holds 2^CNT_W-1 and `ovf_o` goes to 1. The flag stays at 1 until the next configuration write or reset. Reaching exactly 2^CNT_W-1 does not set the flag.
- R4: With selection code 0 (grants), a new transaction is a clock where `master_i` and `start_i` are both 1 and `start_i` was 0 on the previous clock. On such a clock the counter adds the number of bits set in `gnt_i`, so each requester's grant is counted on its own.
- R5: With selection code 0, if `start_i` stays high over several clocks of one transaction, the counter adds grants only on the first of those clocks.
- R6: With selection code 1 (acquisition), the counter adds 1 on every clock where any bit of `req_i` is 1 and `master_i` is 0. This includes clocks where another master owns the bus.
- R7: With selection code 2 (ownership), the counter adds 1 on every clock where `master_i` is 1.
- R8: With selection code 3 (off), `count_o` and `ovf_o` do not change whatever the bus inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NREQ | Request line of each internal requester |
| gnt_i | input | NREQ | Grant line of each internal requester |
| start_i | input | 1 | Transaction-start (frame) indication on the bus |
| master_i | input | 1 | Composite agent is currently driving the bus as master |
| cfg_we_i | input | 1 | Configuration write strobe: loads the selection and clears the counter |
| cfg_sel_i | input | 2 | Event selection: 0 grants, 1 acquisition, 2 ownership, 3 off |
| count_o | output | CNT_W | Current event count |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench uses NREQ = 3 and shrinks CNT_W to 6, so the counter saturates at 63. That limit comes within a few dozen ownership clocks, which brings R3 into reach: it exercises the saturation hold, the sticky flag and clearing the flag by a write. With three grant lines, several grants can land on one transaction start and add more than one at a time. Increments of that size can then step over the limit rather than land on it exactly.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  typedef enum logic [1:0] {
    EV_GRANT = 2'd0,
    EV_ACQ   = 2'd1,
    EV_OWN   = 2'd2,
    EV_OFF   = 2'd3
  } bmon_ev_e;
endpackage

// File: rtl/bmon_edge.sv
// Detects the first clock of a transaction won by the composite agent.
module bmon_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic master_i,
  output logic new_txn_o
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  assign new_txn_o = start_i & ~start_q & master_i;
endmodule

// File: rtl/bmon_evsel.sv
// Turns the selected event into an increment amount for this clock.
module bmon_evsel
  import bmon_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int INC_W = $clog2(NREQ + 1)
) (
  input  bmon_ev_e         sel_i,
  input  logic [NREQ-1:0]  req_i,
  input  logic [NREQ-1:0]  gnt_i,
  input  logic             new_txn_i,
  input  logic             master_i,
  output logic [INC_W-1:0] inc_o
);
  logic             agent_req;
  logic [INC_W-1:0] gnt_sum;

  assign agent_req = |req_i;

  always_comb begin
    gnt_sum = '0;
    for (int k = 0; k < NREQ; k++) begin
      gnt_sum = gnt_sum + INC_W'(gnt_i[k]);
    end
  end

  always_comb begin
    unique case (sel_i)
      EV_GRANT: inc_o = new_txn_i ? gnt_sum : '0;
      EV_ACQ:   inc_o = INC_W'(agent_req & ~master_i);
      EV_OWN:   inc_o = INC_W'(master_i);
      default:  inc_o = '0;
    endcase
  end
endmodule

// File: rtl/bmon_satcnt.sv
// Saturating counter with sticky overflow and synchronous clear.
module bmon_satcnt #(
  parameter int CNT_W = 32,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W:0] LIMIT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (sum > LIMIT) begin
      cnt_q <= {CNT_W{1'b1}};
      ovf_q <= 1'b1;
    end else begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/bmon_top.sv
module bmon_top
  import bmon_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req_i,
  input  logic [NREQ-1:0]  gnt_i,
  input  logic             start_i,
  input  logic             master_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int INC_W = $clog2(NREQ + 1);

  bmon_ev_e         sel_q;
  logic             new_txn;
  logic [INC_W-1:0] inc;

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= EV_OFF;
    else if (cfg_we_i) sel_q <= bmon_ev_e'(cfg_sel_i);
  end

  bmon_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .master_i  (master_i),
    .new_txn_o (new_txn)
  );

  bmon_evsel #(.NREQ(NREQ), .INC_W(INC_W)) u_evsel (
    .sel_i     (sel_q),
    .req_i     (req_i),
    .gnt_i     (gnt_i),
    .new_txn_i (new_txn),
    .master_i  (master_i),
    .inc_o     (inc)
  );

  bmon_satcnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cfg_we_i),
    .inc_i (inc),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );
endmodule

// File: rtl/bmon_checker.sv
module bmon_checker
  import bmon_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_i,
  input logic             start_i,
  input logic             master_i,
  input logic             cfg_we_i,
  input bmon_ev_e         sel_q,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic [CNT_W-1:0] one_more;
  assign one_more = count_o + 1'b1;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (count_o == '0) && !ovf_o);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> count_o == MAXV);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !cfg_we_i) |=> ovf_o);

  p_once_per_txn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == EV_GRANT && start_i && $past(start_i) && !cfg_we_i) |=> $stable(count_o));

  p_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == EV_ACQ && (|req_i) && !master_i && !cfg_we_i && count_o != MAXV)
      |=> count_o == $past(one_more));

  p_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == EV_OWN && master_i && !cfg_we_i && count_o != MAXV)
      |=> count_o == $past(one_more));

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == EV_OFF && !cfg_we_i) |=> $stable(count_o) && $stable(ovf_o));
endmodule

bind bmon_top bmon_checker #(.NREQ(NREQ), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .start_i  (start_i),
  .master_i (master_i),
  .cfg_we_i (cfg_we_i),
  .sel_q    (sel_q),
  .count_o  (count_o),
  .ovf_o    (ovf_o)
);

// File: tb/bmon_top_tb.sv
module bmon_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ  = 3;
  localparam int CNT_W = 6;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NREQ-1:0]  req_i = '0;
  logic [NREQ-1:0]  gnt_i = '0;
  logic             start_i = 1'b0;
  logic             master_i = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_sel_i = 2'd0;
  logic [CNT_W-1:0] count_o;
  logic             ovf_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int m_cnt = 0;
  int m_ovf = 0;
  int m_sel = 3;
  int m_prev_start = 0;

  bmon_top #(.NREQ(NREQ), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .gnt_i(gnt_i),
    .start_i(start_i), .master_i(master_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .count_o(count_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] next_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic compare();
    n_checks++;
    if (int'(count_o) != m_cnt) begin
      n_fail++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count_o, m_cnt);
    end
    n_checks++;
    if (int'(ovf_o) != m_ovf) begin
      n_fail++;
      $display("FAIL %s overflow actual=%0d expected=%0d", tag, ovf_o, m_ovf);
    end
  endtask

  // One clock: check results of the last edge, drive inputs, advance model.
  task automatic cycle(input logic we, input logic [1:0] sel, input logic [NREQ-1:0] rq,
                       input logic [NREQ-1:0] gn, input logic st, input logic ms);
    int inc;
    @(negedge clk);
    compare();
    cfg_we_i = we; cfg_sel_i = sel; req_i = rq; gnt_i = gn;
    start_i = st; master_i = ms;
    inc = 0;
    case (m_sel)
      0: if (ms && st && m_prev_start == 0) inc = $countones(gn);
      1: if (rq != 0 && !ms) inc = 1;
      2: if (ms) inc = 1;
      default: inc = 0;
    endcase
    if (we) begin
      m_cnt = 0; m_ovf = 0; m_sel = int'(sel);
    end else if (m_cnt + inc > MAXV) begin
      m_cnt = MAXV; m_ovf = 1;
    end else begin
      m_cnt = m_cnt + inc;
    end
    m_prev_start = int'(st);
  endtask

  task automatic random_run(input int n, input int dense);
    for (int i = 0; i < n; i++) begin
      lfsr = next_lfsr(lfsr);
      cycle(1'b0, 2'd0, lfsr[2:0], lfsr[5:3], lfsr[6] & (lfsr[7] | dense[0]),
            lfsr[8] | lfsr[9]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    cycle(1'b0, 2'd0, 3'b111, 3'b111, 1'b1, 1'b1);
    cycle(1'b0, 2'd0, 3'b101, 3'b000, 1'b0, 1'b0);
    random_run(20, 1);

    // R4: grant counting, several grants per start
    tag = "R4";
    cycle(1'b1, 2'd0, 3'b111, 3'b111, 1'b1, 1'b1); // write with event present
    cycle(1'b0, 2'd0, 3'b001, 3'b011, 1'b0, 1'b1);
    cycle(1'b0, 2'd0, 3'b001, 3'b011, 1'b1, 1'b1);
    cycle(1'b0, 2'd0, 3'b000, 3'b111, 1'b0, 1'b1);
    cycle(1'b0, 2'd0, 3'b000, 3'b100, 1'b1, 1'b0); // not master
    cycle(1'b0, 2'd0, 3'b000, 3'b100, 1'b0, 1'b0);
    random_run(60, 0);

    // R5: start held over several clocks
    tag = "R5";
    cycle(1'b1, 2'd0, 3'b000, 3'b000, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b0, 2'd0, 3'b010, 3'b010, 1'b1, 1'b1);
    cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 2'd0, 3'b110, 3'b110, 1'b1, 1'b1);

    // R6: acquisition clocks, including another master owning the bus
    tag = "R6";
    cycle(1'b1, 2'd1, 3'b000, 3'b000, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cycle(1'b0, 2'd0, 3'b100, 3'b000, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b0, 2'd0, 3'b100, 3'b100, 1'b1, 1'b1);
    random_run(40, 1);

    // R7: ownership clocks
    tag = "R7";
    cycle(1'b1, 2'd2, 3'b000, 3'b000, 1'b0, 1'b0);
    random_run(40, 1);

    // R3: saturation and sticky flag
    tag = "R3";
    cycle(1'b1, 2'd2, 3'b000, 3'b000, 1'b0, 1'b1);
    for (int i = 0; i < MAXV + 6; i++) cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b0);
    cycle(1'b1, 2'd0, 3'b000, 3'b000, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      cycle(1'b0, 2'd0, 3'b111, 3'b111, 1'b1, 1'b1);
      cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b1);
    end

    // R2: write clears mid-run and while saturated
    tag = "R2";
    cycle(1'b1, 2'd2, 3'b000, 3'b000, 1'b0, 1'b1);
    cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b1);
    cycle(1'b1, 2'd1, 3'b001, 3'b000, 1'b0, 1'b0);
    cycle(1'b0, 2'd0, 3'b001, 3'b000, 1'b0, 1'b0);

    // R8: off code ignores all bus activity
    tag = "R8";
    for (int i = 0; i < 5; i++) cycle(1'b0, 2'd0, 3'b001, 3'b000, 1'b0, 1'b0);
    cycle(1'b1, 2'd3, 3'b111, 3'b111, 1'b1, 1'b1);
    random_run(50, 1);
    cycle(1'b0, 2'd0, 3'b000, 3'b000, 1'b0, 1'b0);
    @(negedge clk);
    compare();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule